// File: doc/BRIEF.md
# Burst Bus Master Strobe Sequencer

This block drives an external parallel device as bus master. It moves a burst of data words from a transmit FIFO out to the device, or from the device into a receive FIFO. A single strobe line marks each word: it goes high for one phase and low for the next. A direction line stays high for the whole of an outbound burst. Every edge of these lines falls on a tick of an internal timebase, and that timebase is the system clock divided by a programmable ratio.

The divider ratio, the minimum phase length, the beat count, the inbound capture edge and the wait-handshake enable are plain inputs. The block samples them when a burst is accepted. A one-cycle start request launches the burst, and a read start wins over a write start. Each phase can be stretched by the external wait line. The burst pauses, with the strobe frozen, while the transmit FIFO is empty or the receive FIFO is full. A one-cycle completion pulse ends the burst.

Top module: `bmb_top`

## Requirements
- R1: After reset, and whenever no burst is active, `bus_strobe_o`, `bus_write_o`, `tx_pop_o`, `rx_push_o` and `done_o` are low.
- R2: While a burst runs, a tick occurs every `div_i+1` system clocks. The divider is held cleared while idle, so the first tick comes `div_i+1` clocks after the accept edge.
- R3: A burst begins with one low setup phase. It then gives exactly `count_i+1` strobe high phases, each followed by a low phase.
- R4: A phase ends on the tick where `ws_i+1` ticks of that phase have elapsed. If the wait handshake was enabled at the start of the burst, a tick seen while `ext_wait_i` is high does not end the phase, and the phase continues on later ticks.
- R5: When the wait handshake was disabled at the start of the burst, `ext_wait_i` has no effect on the timing of any output.
- R6: In an outbound burst, `bus_write_o` rises in the cycle after the accept edge. It stays high without a gap until the cycle in which `done_o` is high.
- R7: In an outbound burst, `tx_pop_o` pulses in the cycle at whose end the strobe rises, and `bus_data_o` shows the popped word from then on. A low phase that would start a strobe does not end while `tx_empty_i` is high.
- R8: In an inbound burst with `latch_rise_i`=0, `rx_push_o` pulses, with `rx_data_o`=`bus_data_i`, in the last cycle of every strobe high phase (the falling edge).
- R9: In an inbound burst with `latch_rise_i`=1, the push happens in the last cycle of every low phase that follows a high phase. This is the next rising edge, or, for the final word, the tick that ends the burst.
- R10: In an inbound burst, no phase ends and no push occurs while `rx_full_i` is high.
- R11: `done_o` is high for exactly one system clock. That clock is the first idle cycle after the final low phase.
- R12: Start requests that arrive while a burst is active are ignored. If both start requests are high in an idle cycle, an inbound burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Tick ratio minus one |
| ws_i | input | WS_W | Extra ticks per phase |
| count_i | input | CNT_W | Beats per burst minus one |
| latch_rise_i | input | 1 | Inbound capture on next rising edge when 1 |
| wait_en_i | input | 1 | Enables the external wait handshake |
| rd_start_i | input | 1 | Start an inbound burst (pulse) |
| wr_start_i | input | 1 | Start an outbound burst (pulse) |
| ext_wait_i | input | 1 | External wait, high stretches a phase |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | DATA_W | Transmit FIFO head word |
| tx_pop_o | output | 1 | Transmit FIFO pop |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Receive FIFO push |
| rx_data_o | output | DATA_W | Word pushed into the receive FIFO |
| bus_data_i | input | DATA_W | Data bus from the device |
| bus_data_o | output | DATA_W | Data bus to the device |
| bus_strobe_o | output | 1 | Strobe, high phase marks a beat |
| bus_write_o | output | 1 | Direction, high during an outbound burst |
| done_o | output | 1 | Burst complete pulse |

## Verification
In rising-edge capture mode, the push of one word and the rise of the next strobe fall on the same system clock. That same clock is also where a full receive FIFO must freeze both actions together. The bench raises `rx_full_i` for a stretch of cycles in the middle of such a burst. A behavioural model with its own counters predicts every output on every clock, so a push that slips a cycle away from its strobe edge, or a strobe that starts while the FIFO is full, shows up as a mismatch. A second overlap, a FIFO stall arriving on the same tick as a wait stretch, is provoked by an outbound burst that runs with the wait handshake on and a nearly empty transmit FIFO.

// File: rtl/bmb_pkg.sv
package bmb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } bmb_state_e;

  typedef struct packed {
    logic wr;
    logic rise_mode;
    logic wait_en;
  } bmb_mode_t;
endpackage

// File: rtl/bmb_tick_gen.sv
module bmb_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bmb_phase_timer.sv
module bmb_phase_timer #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            clear_i,
  input  logic            hold_i,
  input  logic [WS_W-1:0] ws_i,
  output logic            ripe_o
);
  logic [WS_W-1:0] ph_q, ph_d;
  logic            at_limit;

  assign at_limit = (ph_q == ws_i);
  assign ripe_o   = tick_i && at_limit && !hold_i;

  always_comb begin
    ph_d = ph_q;
    if (clear_i)                 ph_d = '0;
    else if (tick_i && !at_limit) ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/bmb_sequencer.sv
module bmb_sequencer
  import bmb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_start_i,
  input  logic             wr_start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rise_mode_i,
  input  logic             wait_en_i,
  input  logic             ripe_i,
  input  logic             tx_empty_i,
  input  logic             rx_full_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             phase_end_o,
  output logic             wait_en_o,
  output logic             strobe_o,
  output logic             write_o,
  output logic             pop_o,
  output logic             push_o,
  output logic             done_o
);
  localparam int BEAT_W = CNT_W + 1;

  bmb_state_e        state_q, state_d;
  bmb_mode_t         mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beats_q, beats_d;
  logic              done_q, done_d;
  logic              final_low, res_ok;

  assign busy_o    = (state_q != ST_IDLE);
  assign accept_o  = !busy_o && (rd_start_i || wr_start_i);
  assign final_low = (beats_q == ({1'b0, cnt_q} + 1'b1));
  assign res_ok    = mode_q.wr ? !((state_q == ST_LOW) && !final_low && tx_empty_i)
                               : !rx_full_i;
  assign phase_end_o = busy_o && ripe_i && res_ok;
  assign wait_en_o   = mode_q.wait_en;
  assign strobe_o    = (state_q == ST_HIGH);
  assign write_o     = busy_o && mode_q.wr;
  assign pop_o       = mode_q.wr && phase_end_o && (state_q == ST_LOW) && !final_low;
  assign push_o      = !mode_q.wr && phase_end_o &&
                       (mode_q.rise_mode ? ((state_q == ST_LOW) && (beats_q != '0))
                                         : (state_q == ST_HIGH));
  assign done_o      = done_q;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    beats_d = beats_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        state_d        = ST_LOW;
        mode_d.wr      = !rd_start_i;
        mode_d.rise_mode = rise_mode_i;
        mode_d.wait_en = wait_en_i;
        cnt_d          = count_i;
        beats_d        = '0;
      end
      ST_LOW: if (phase_end_o) begin
        if (final_low) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_HIGH;
        end
      end
      ST_HIGH: if (phase_end_o) begin
        state_d = ST_LOW;
        beats_d = beats_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      cnt_q   <= '0;
      beats_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      beats_q <= beats_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/bmb_top.sv
module bmb_top #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter int WS_W   = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              latch_rise_i,
  input  logic              wait_en_i,
  input  logic              rd_start_i,
  input  logic              wr_start_i,
  input  logic              ext_wait_i,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_strobe_o,
  output logic              bus_write_o,
  output logic              done_o
);
  logic [DIV_W-1:0]  div_q;
  logic [WS_W-1:0]   ws_q;
  logic [DATA_W-1:0] dout_q;
  logic accept, busy, phase_end, wait_en_q, tick, ripe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ws_q   <= '0;
      dout_q <= '0;
    end else begin
      if (accept) begin
        div_q <= div_i;
        ws_q  <= ws_i;
      end
      if (tx_pop_o) dout_q <= tx_data_i;
    end
  end

  bmb_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(div_q), .tick_o(tick)
  );

  bmb_phase_timer #(.WS_W(WS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .clear_i(phase_end || !busy),
    .hold_i(wait_en_q && ext_wait_i), .ws_i(ws_q), .ripe_o(ripe)
  );

  bmb_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_start_i(rd_start_i), .wr_start_i(wr_start_i),
    .count_i(count_i), .rise_mode_i(latch_rise_i), .wait_en_i(wait_en_i),
    .ripe_i(ripe), .tx_empty_i(tx_empty_i), .rx_full_i(rx_full_i),
    .accept_o(accept), .busy_o(busy), .phase_end_o(phase_end),
    .wait_en_o(wait_en_q), .strobe_o(bus_strobe_o), .write_o(bus_write_o),
    .pop_o(tx_pop_o), .push_o(rx_push_o), .done_o(done_o)
  );

  assign rx_data_o  = bus_data_i;
  assign bus_data_o = dout_q;
endmodule

// File: rtl/bmb_checker.sv
module bmb_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_strobe_o,
  input logic bus_write_o,
  input logic tx_pop_o,
  input logic tx_empty_i,
  input logic rx_push_o,
  input logic rx_full_i,
  input logic done_o
);
  // R6
  write_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_write_o) |-> done_o);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R1
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!bus_strobe_o && !bus_write_o));
  // R7
  pop_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |-> !tx_empty_i);
  // R7
  pop_then_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |=> $rose(bus_strobe_o));
  // R10
  push_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |-> !rx_full_i);
  // R12
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_push_o && tx_pop_o));
endmodule

bind bmb_top bmb_checker u_bmb_checker (
  .clk(clk), .rst_n(rst_n), .bus_strobe_o(bus_strobe_o),
  .bus_write_o(bus_write_o), .tx_pop_o(tx_pop_o), .tx_empty_i(tx_empty_i),
  .rx_push_o(rx_push_o), .rx_full_i(rx_full_i), .done_o(done_o)
);

// File: tb/bmb_top_bench.sv
module bmb_top_bench;
  localparam int DATA_W = 16;
  localparam int DIV_W = 4;
  localparam int WS_W = 3;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0]  div_i = '0;
  logic [WS_W-1:0]   ws_i = '0;
  logic [CNT_W-1:0]  count_i = '0;
  logic latch_rise_i = 1'b0, wait_en_i = 1'b0, rd_start_i = 1'b0, wr_start_i = 1'b0;
  logic ext_wait_i = 1'b0, tx_empty_i = 1'b1, rx_full_i = 1'b0;
  logic [DATA_W-1:0] tx_data_i = '0, bus_data_i = 16'h0100;
  logic tx_pop_o, rx_push_o, bus_strobe_o, bus_write_o, done_o;
  logic [DATA_W-1:0] rx_data_o, bus_data_o;

  always #2 clk = ~clk;

  bmb_top u_bmb_top (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .ws_i(ws_i), .count_i(count_i),
    .latch_rise_i(latch_rise_i), .wait_en_i(wait_en_i), .rd_start_i(rd_start_i),
    .wr_start_i(wr_start_i), .ext_wait_i(ext_wait_i), .tx_empty_i(tx_empty_i),
    .tx_data_i(tx_data_i), .tx_pop_o(tx_pop_o), .rx_full_i(rx_full_i),
    .rx_push_o(rx_push_o), .rx_data_o(rx_data_o), .bus_data_i(bus_data_i),
    .bus_data_o(bus_data_o), .bus_strobe_o(bus_strobe_o),
    .bus_write_o(bus_write_o), .done_o(done_o)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [DATA_W-1:0] tx_q[$];

  // reference model: 0 idle, 1 low, 2 high
  int m_st = 0, m_divc = 0, m_ph = 0, m_beats = 0;
  int m_div = 0, m_ws = 0, m_cnt = 0;
  bit m_rd = 0, m_rise = 0, m_wen = 0, m_done = 0, m_pop_pend = 0;
  logic [DATA_W-1:0] m_dout = '0;
  int rises = 0;
  logic prev_strobe = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic refresh_tx();
    tx_empty_i = (tx_q.size() == 0);
    tx_data_i  = (tx_q.size() == 0) ? '0 : tx_q[0];
  endtask

  function automatic bit m_pe();
    bit tick, ripe, res, fin;
    tick = (m_st != 0) && (m_divc == m_div);
    ripe = tick && (m_ph == m_ws) && !(m_wen && ext_wait_i);
    fin  = (m_beats == m_cnt + 1);
    res  = m_rd ? !rx_full_i : !((m_st == 1) && !fin && tx_empty_i);
    return ripe && res;
  endfunction

  function automatic bit m_pop();
    return !m_rd && (m_st == 1) && m_pe() && (m_beats != m_cnt + 1);
  endfunction

  function automatic bit m_push();
    return m_rd && m_pe() && (m_rise ? ((m_st == 1) && (m_beats > 0)) : (m_st == 2));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_divc = 0; m_ph = 0;
    end else begin
      bit pe, tick;
      pe = m_pe();
      tick = (m_st != 0) && (m_divc == m_div);
      m_done = 0;
      if (m_pop()) begin
        m_dout = tx_q[0];
        m_pop_pend = 1;
      end
      if (m_st == 0) begin
        m_divc = 0; m_ph = 0;
        if (rd_start_i || wr_start_i) begin
          m_st = 1; m_rd = rd_start_i; m_rise = latch_rise_i; m_wen = wait_en_i;
          m_div = int'(div_i); m_ws = int'(ws_i); m_cnt = int'(count_i); m_beats = 0;
        end
      end else begin
        m_divc = tick ? 0 : m_divc + 1;
        if (pe) m_ph = 0;
        else if (tick && m_ph != m_ws) m_ph = m_ph + 1;
        if (pe && m_st == 1) begin
          if (m_beats == m_cnt + 1) begin m_st = 0; m_done = 1; end
          else m_st = 2;
        end else if (pe && m_st == 2) begin
          m_st = 1; m_beats = m_beats + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(bus_strobe_o == (m_st == 2), "R3", "strobe", bus_strobe_o, m_st == 2);
      check(bus_write_o == ((m_st != 0) && !m_rd), "R6", "write", bus_write_o, (m_st != 0) && !m_rd);
      check(done_o == m_done, "R11", "done", done_o, m_done);
      check(tx_pop_o == m_pop(), "R7", "pop", tx_pop_o, m_pop());
      check(rx_push_o == m_push(), m_rise ? "R9" : "R8", "push", rx_push_o, m_push());
      if (m_push()) check(rx_data_o == bus_data_i, "R8", "rx data", rx_data_o, bus_data_i);
      check(bus_data_o == m_dout, "R7", "bus data", bus_data_o, m_dout);
      if (bus_strobe_o && !prev_strobe) rises++;
      prev_strobe = bus_strobe_o;
      if (m_pop_pend) begin
        void'(tx_q.pop_front());
        m_pop_pend = 0;
        refresh_tx();
      end
      bus_data_i = bus_data_i + 16'd3;
    end
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog: actual 0 expected 1 (done never seen)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic start(input bit rd, input bit wr);
    step();
    rd_start_i = rd; wr_start_i = wr;
    step();
    rd_start_i = 0; wr_start_i = 0;
  endtask

  task automatic wait_done(input string req, input int exp_rises);
    int n;
    n = 0;
    while (!done_o && n < 5000) begin step(); n++; end
    check(done_o == 1'b1, req, "done seen", done_o, 1);
    check(rises == exp_rises, "R3", "strobe count", rises, exp_rises);
    step();
    rises = 0;
  endtask

  task automatic cfg(input int d, input int w, input int c, input bit rise, input bit we);
    div_i = DIV_W'(d); ws_i = WS_W'(w); count_i = CNT_W'(c);
    latch_rise_i = rise; wait_en_i = we;
  endtask

  initial begin
    refresh_tx();
    repeat (3) step();
    // R1: reset state
    check(!bus_strobe_o && !bus_write_o && !done_o && !tx_pop_o && !rx_push_o,
          "R1", "reset outputs", {bus_strobe_o, bus_write_o, done_o}, 0);
    rst_n = 1'b1;
    step();
    check(!bus_strobe_o && !bus_write_o, "R1", "idle outputs", bus_strobe_o, 0);

    // R3 R7: outbound, fastest timing
    for (int i = 0; i < 4; i++) tx_q.push_back(DATA_W'(16'hA000 + i));
    refresh_tx();
    cfg(0, 0, 3, 0, 0);
    start(0, 1);
    wait_done("R6", 4);

    // R2 R7: outbound with divider, FIFO runs dry mid-burst
    tx_q.push_back(16'hB001); refresh_tx();
    cfg(2, 1, 2, 0, 0);
    start(0, 1);
    repeat (40) step();
    tx_q.push_back(16'hB002); tx_q.push_back(16'hB003); refresh_tx();
    wait_done("R7", 3);

    // R8: inbound, falling-edge capture
    cfg(1, 0, 3, 0, 0);
    start(1, 0);
    wait_done("R8", 4);

    // R9 R10: inbound, rising-edge capture, receive FIFO fills mid-burst
    cfg(0, 1, 2, 1, 0);
    start(1, 0);
    repeat (5) step();
    rx_full_i = 1'b1;
    repeat (9) step();
    rx_full_i = 1'b0;
    wait_done("R9", 3);

    // R4: outbound with wait handshake and stall
    tx_q.push_back(16'hC001); refresh_tx();
    cfg(1, 0, 1, 0, 1);
    start(0, 1);
    for (int i = 0; i < 6; i++) begin ext_wait_i = 1'b1; step(); ext_wait_i = 1'b0; step(); end
    tx_q.push_back(16'hC002); refresh_tx();
    ext_wait_i = 1'b1; repeat (7) step(); ext_wait_i = 1'b0;
    wait_done("R4", 2);

    // R5: wait line held high but handshake disabled
    cfg(0, 2, 2, 0, 0);
    ext_wait_i = 1'b1;
    start(1, 0);
    wait_done("R5", 3);
    ext_wait_i = 1'b0;

    // R12: both starts -> inbound; starts while busy ignored
    cfg(0, 0, 1, 1, 0);
    start(1, 1);
    check(bus_write_o == 1'b0, "R12", "read priority", bus_write_o, 0);
    tx_q.push_back(16'hD001); refresh_tx();
    wr_start_i = 1'b1; step(); wr_start_i = 1'b0;
    wait_done("R12", 2);
    check(bus_write_o == 1'b0 && tx_q.size() == 1, "R12", "busy start ignored", tx_q.size(), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule